// File: doc/BRIEF.md
# Multicart Outer-Bank Supervisor Registers

This block is the supervisor register set of a multicart controller. It watches CPU writes and reads at a handful of addresses in the 0x5000–0x5FFF range. It holds four things: the code that selects which inner mapper is active, four mode flags for that mapper, a composite outer program-ROM offset built from fields of several registers, and a miscellaneous register that software can lock once. It also produces a one-cycle pulse that clears all inner-mapper state whenever a new mapper is selected.

A small serial configuration EEPROM sits beside the block. Its chip-select, clock and data pins are driven from CPU writes, and the address that carries them depends on the build-time `VARIANT` parameter. Variant 1 also has a second miscellaneous register. The EEPROM's serial output bit comes back to the CPU on reads of two status addresses. The inner mappers and the EEPROM are outside this block.

Top module: `mcart_sup_regs`

## Requirements
- R1: After reset: `map_sel` = VARIANT in bits 7:4 and 0 in bits 3:0, `map_flags` = 0xF, `prg_ofs` = 0x7FF0, `misc_q` = 0, `misc2_q` = 0, `misc_locked` = 0, `inner_clr` = 0, and the EEPROM pins are select=1, clock=1, data=0.
- R2: A write to 0x5700 loads `map_sel` bits 3:0 from data bits 7:4 (bits 7:4 stay VARIANT), loads `map_flags` from data bits 3:0, copies data bit 0 into `prg_ofs` bit 4, and raises `inner_clr` for exactly the one cycle after the write edge.
- R3: A write to 0x5701 loads data bits 7:0 into `prg_ofs` bits 12:5.
- R4: A write to 0x5601 loads `misc_q` only while `misc_q` bit 7 is 0. `misc_locked` mirrors that bit, and once it is set, further 0x5601 writes leave `misc_q` unchanged until reset.
- R5: An accepted 0x5601 write copies data bit 4 into `prg_ofs` bit 13 in every variant except 1. In variant 1 that bit keeps its reset value.
- R6: In variant 0, a write to 0x5301 sets EEPROM select, clock and data from data bits 2, 1 and 0. A write to 0x5601 does not touch the pins.
- R7: In variant 1, every write to 0x5601 sets select, clock and data from data bits 4, 1 and 0, locked or not. Writes to 0x5301 do not touch the pins. A write to 0x5702 loads `misc2_q`. In any other variant, `misc2_q` stays 0.
- R8: `cpu_rdata` is 0x80 when `cpu_addr` is 0x5301 or 0x5601 and `ee_do` is 1, and 0x00 at those addresses when `ee_do` is 0. Every other address reads 0xFF.
- R9: `prg_ofs` bits 3:0, 14 and 15 always hold their reset values. Writes to addresses other than the five decoded ones change no output.
- R10: A register write is not visible during its strobe cycle. It appears on the outputs after the rising edge that samples `cpu_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | ADDR_W | CPU address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_wr | input | 1 | Write strobe, sampled on the rising edge |
| cpu_rdata | output | DATA_W | Combinational read data |
| ee_do | input | 1 | EEPROM serial output bit |
| ee_sel | output | 1 | EEPROM select pin |
| ee_clk | output | 1 | EEPROM clock pin |
| ee_dat | output | 1 | EEPROM data-in pin |
| map_sel | output | DATA_W | Inner-mapper select code |
| map_flags | output | DATA_W/2 | Inner-mapper mode flags |
| prg_ofs | output | OFS_W | Outer program-ROM offset |
| misc_q | output | DATA_W | Lockable miscellaneous register |
| misc2_q | output | DATA_W | Second miscellaneous register (variant 1) |
| misc_locked | output | 1 | Lock status of `misc_q` |
| inner_clr | output | 1 | One-cycle clear pulse for the inner mapper |

## Verification
The bench drives two copies of the block, variant 0 and variant 1, with the same bus traffic. It sweeps every data value through the select and offset registers, so a swapped nibble, a wrong offset bit position or a missing clear pulse would show up as a wrong field value. The lock sequence writes with bit 7 clear, then sets bit 7, then writes again. A design that checked the new data instead of the stored lock bit would keep loading `misc_q` and would keep moving offset bit 13 in variant 0. The same sequence catches a variant-1 build that stopped driving the EEPROM pins once locked. A sweep over the whole decode window with both levels of `ee_do` catches a misdecoded status address or a misplaced output bit.

// File: rtl/mcart_sup_pkg.sv
package mcart_sup_pkg;

   // One-hot decode of the bus cycle on the current address.
   typedef struct packed {
      logic sel_wr;    // mapper select / flags write
      logic ofs_wr;    // outer offset middle field write
      logic misc_wr;   // lockable misc write
      logic misc2_wr;  // second misc write
      logic eep_wr;    // EEPROM pin write (variant 0 address)
      logic st_rd;     // status read address
   } hit_t;

   // EEPROM pin bundle: select, clock, data.
   typedef struct packed {
      logic sel;
      logic clk;
      logic dat;
   } eepins_t;

   localparam eepins_t PINS_RST = '{sel: 1'b1, clk: 1'b1, dat: 1'b0};

endpackage

// File: rtl/mcart_sup_decode.sv
module mcart_sup_decode
   import mcart_sup_pkg::*;
#(
   parameter int                ADDR_W  = 16,
   parameter logic [ADDR_W-1:0] A_SEL   = 16'h5700,
   parameter logic [ADDR_W-1:0] A_OFS   = 16'h5701,
   parameter logic [ADDR_W-1:0] A_MISC  = 16'h5601,
   parameter logic [ADDR_W-1:0] A_MISC2 = 16'h5702,
   parameter logic [ADDR_W-1:0] A_EEP   = 16'h5301
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output hit_t              hit
);

   logic is_sel, is_ofs, is_misc, is_misc2, is_eep;

   always_comb begin
      is_sel   = (addr == A_SEL);
      is_ofs   = (addr == A_OFS);
      is_misc  = (addr == A_MISC);
      is_misc2 = (addr == A_MISC2);
      is_eep   = (addr == A_EEP);
   end

   always_comb begin
      hit.sel_wr   = wr & is_sel;
      hit.ofs_wr   = wr & is_ofs;
      hit.misc_wr  = wr & is_misc;
      hit.misc2_wr = wr & is_misc2;
      hit.eep_wr   = wr & is_eep;
      hit.st_rd    = is_eep | is_misc;
   end

endmodule

// File: rtl/mcart_sup_core.sv
module mcart_sup_core #(
   parameter int                  VARIANT   = 0,
   parameter int                  DATA_W    = 8,
   parameter int                  OFS_W     = 16,
   parameter logic [OFS_W-1:0]    OFS_RST   = 16'h7FF0,
   parameter logic [DATA_W/2-1:0] FLAGS_RST = '1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [DATA_W-1:0]     wdata,
   input  logic                  sel_wr,
   input  logic                  ofs_wr,
   input  logic                  misc_wr,
   input  logic                  misc2_wr,
   output logic [DATA_W-1:0]     map_sel,
   output logic [DATA_W/2-1:0]   map_flags,
   output logic [OFS_W-1:0]      prg_ofs,
   output logic [DATA_W-1:0]     misc_q,
   output logic [DATA_W-1:0]     misc2_q,
   output logic                  inner_clr
);

   localparam int NIB_W    = DATA_W / 2;
   localparam int B4_POS   = 4;
   localparam int MID_LO   = 5;
   localparam int MID_HI   = MID_LO + DATA_W - 1;
   localparam int B13_POS  = MID_HI + 1;
   localparam int TOP_LO   = B13_POS + 1;
   localparam logic [NIB_W-1:0] VAR_NIB = NIB_W'(VARIANT);

   logic [NIB_W-1:0]  sel_lo;
   logic              ofs_b4;
   logic [DATA_W-1:0] ofs_mid;
   logic              ofs_b13;
   logic              misc_take;

   // Lock is the stored top bit, never the incoming data.
   assign misc_take = misc_wr & ~misc_q[DATA_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_lo    <= '0;
         map_flags <= FLAGS_RST;
         inner_clr <= 1'b0;
      end else begin
         inner_clr <= sel_wr;
         if (sel_wr) begin
            sel_lo    <= wdata[DATA_W-1:NIB_W];
            map_flags <= wdata[NIB_W-1:0];
         end
      end
   end

   assign map_sel = {VAR_NIB, sel_lo};

   always_ff @(posedge clk) begin
      if (!rst_n)      ofs_b4 <= OFS_RST[B4_POS];
      else if (sel_wr) ofs_b4 <= wdata[0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      ofs_mid <= OFS_RST[MID_HI:MID_LO];
      else if (ofs_wr) ofs_mid <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         misc_q <= '0;
      else if (misc_take) misc_q <= wdata;
   end

   generate
      if (VARIANT == 1) begin : g_v1
         // Offset bit 13 is not driven by the misc register here.
         assign ofs_b13 = OFS_RST[B13_POS];
         always_ff @(posedge clk) begin
            if (!rst_n)        misc2_q <= '0;
            else if (misc2_wr) misc2_q <= wdata;
         end
      end else begin : g_vx
         logic unused_m2;
         logic b13_q;
         assign unused_m2 = misc2_wr;
         always_ff @(posedge clk) begin
            if (!rst_n)         b13_q <= OFS_RST[B13_POS];
            else if (misc_take) b13_q <= wdata[4];
         end
         assign ofs_b13 = b13_q;
         assign misc2_q = '0;
      end
   endgenerate

   assign prg_ofs = {OFS_RST[OFS_W-1:TOP_LO], ofs_b13, ofs_mid, ofs_b4,
                     OFS_RST[B4_POS-1:0]};

endmodule

// File: rtl/mcart_sup_pins.sv
module mcart_sup_pins
   import mcart_sup_pkg::*;
#(
   parameter int VARIANT = 0,
   parameter int DATA_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wdata,
   input  logic              eep_wr,
   input  logic              misc_wr,
   output eepins_t           pins
);

   logic    pin_ld;
   eepins_t pin_nxt;

   generate
      if (VARIANT == 0) begin : g_v0
         logic unused_v0;
         assign unused_v0 = ^{misc_wr, wdata[DATA_W-1:3]};
         assign pin_ld    = eep_wr;
         assign pin_nxt   = '{sel: wdata[2], clk: wdata[1], dat: wdata[0]};
      end else if (VARIANT == 1) begin : g_v1
         logic unused_v1;
         assign unused_v1 = ^{eep_wr, wdata[DATA_W-1:5], wdata[3:2]};
         assign pin_ld    = misc_wr;
         assign pin_nxt   = '{sel: wdata[4], clk: wdata[1], dat: wdata[0]};
      end else begin : g_none
         logic unused_vn;
         assign unused_vn = ^{eep_wr, misc_wr, wdata};
         assign pin_ld    = 1'b0;
         assign pin_nxt   = PINS_RST;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      pins <= PINS_RST;
      else if (pin_ld) pins <= pin_nxt;
   end

endmodule

// File: rtl/mcart_sup_regs.sv
module mcart_sup_regs
   import mcart_sup_pkg::*;
#(
   parameter int                  VARIANT   = 0,
   parameter int                  ADDR_W    = 16,
   parameter int                  DATA_W    = 8,
   parameter int                  OFS_W     = 16,
   parameter logic [OFS_W-1:0]    OFS_RST   = 16'h7FF0,
   parameter logic [DATA_W/2-1:0] FLAGS_RST = '1,
   parameter logic [ADDR_W-1:0]   A_SEL     = 16'h5700,
   parameter logic [ADDR_W-1:0]   A_OFS     = 16'h5701,
   parameter logic [ADDR_W-1:0]   A_MISC    = 16'h5601,
   parameter logic [ADDR_W-1:0]   A_MISC2   = 16'h5702,
   parameter logic [ADDR_W-1:0]   A_EEP     = 16'h5301
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     cpu_addr,
   input  logic [DATA_W-1:0]     cpu_wdata,
   input  logic                  cpu_wr,
   output logic [DATA_W-1:0]     cpu_rdata,
   input  logic                  ee_do,
   output logic                  ee_sel,
   output logic                  ee_clk,
   output logic                  ee_dat,
   output logic [DATA_W-1:0]     map_sel,
   output logic [DATA_W/2-1:0]   map_flags,
   output logic [OFS_W-1:0]      prg_ofs,
   output logic [DATA_W-1:0]     misc_q,
   output logic [DATA_W-1:0]     misc2_q,
   output logic                  misc_locked,
   output logic                  inner_clr
);

   localparam int PAD_W = DATA_W - 1;

   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("mcart_sup_regs: DATA_W must be 8");
      end
      if (OFS_W < 15 || OFS_W > 32) begin : g_bad_ofs
         $error("mcart_sup_regs: OFS_W must be within 15..32");
      end
      if (VARIANT < 0 || VARIANT > 15) begin : g_bad_var
         $error("mcart_sup_regs: VARIANT must be within 0..15");
      end
      if (ADDR_W < 16) begin : g_bad_addr
         $error("mcart_sup_regs: ADDR_W must be at least 16");
      end
   endgenerate

   hit_t    hit;
   eepins_t pins;

   mcart_sup_decode #(
      .ADDR_W (ADDR_W),
      .A_SEL  (A_SEL),
      .A_OFS  (A_OFS),
      .A_MISC (A_MISC),
      .A_MISC2(A_MISC2),
      .A_EEP  (A_EEP)
   ) u_dec (
      .addr(cpu_addr),
      .wr  (cpu_wr),
      .hit (hit)
   );

   mcart_sup_core #(
      .VARIANT  (VARIANT),
      .DATA_W   (DATA_W),
      .OFS_W    (OFS_W),
      .OFS_RST  (OFS_RST),
      .FLAGS_RST(FLAGS_RST)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .wdata    (cpu_wdata),
      .sel_wr   (hit.sel_wr),
      .ofs_wr   (hit.ofs_wr),
      .misc_wr  (hit.misc_wr),
      .misc2_wr (hit.misc2_wr),
      .map_sel  (map_sel),
      .map_flags(map_flags),
      .prg_ofs  (prg_ofs),
      .misc_q   (misc_q),
      .misc2_q  (misc2_q),
      .inner_clr(inner_clr)
   );

   mcart_sup_pins #(
      .VARIANT(VARIANT),
      .DATA_W (DATA_W)
   ) u_pins (
      .clk    (clk),
      .rst_n  (rst_n),
      .wdata  (cpu_wdata),
      .eep_wr (hit.eep_wr),
      .misc_wr(hit.misc_wr),
      .pins   (pins)
   );

   assign ee_sel      = pins.sel;
   assign ee_clk      = pins.clk;
   assign ee_dat      = pins.dat;
   assign misc_locked = misc_q[DATA_W-1];

   always_comb begin
      if (hit.st_rd) cpu_rdata = {ee_do, {PAD_W{1'b0}}};
      else           cpu_rdata = '1;
   end

endmodule

// File: rtl/mcart_sup_chk.sv
module mcart_sup_chk #(
   parameter int                ADDR_W = 16,
   parameter int                DATA_W = 8,
   parameter int                OFS_W  = 16,
   parameter logic [ADDR_W-1:0] A_SEL  = 16'h5700,
   parameter logic [ADDR_W-1:0] A_OFS  = 16'h5701
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic              cpu_wr,
   input logic [DATA_W-1:0] cpu_rdata,
   input logic              ee_sel,
   input logic              ee_clk,
   input logic              ee_dat,
   input logic [OFS_W-1:0]  prg_ofs,
   input logic [DATA_W-1:0] misc_q,
   input logic              misc_locked,
   input logic              inner_clr
);

   AST_CLR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      inner_clr |-> $past(cpu_wr && (cpu_addr == A_SEL)));  // R2

   AST_OFS_MID_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && (cpu_addr == A_OFS)) |=> (prg_ofs[12:5] == $past(cpu_wdata)));  // R3

   AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      misc_locked |=> ($stable(misc_q) && misc_locked));  // R4

   AST_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_wr |=> $stable({ee_sel, ee_clk, ee_dat}));  // R6

   AST_RD_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rdata == '1) || (cpu_rdata[DATA_W-2:0] == '0));  // R8

   AST_OFS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_wr |=> $stable(prg_ofs));  // R9

endmodule

bind mcart_sup_regs mcart_sup_chk #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W),
   .OFS_W (OFS_W),
   .A_SEL (A_SEL),
   .A_OFS (A_OFS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_addr   (cpu_addr),
   .cpu_wdata  (cpu_wdata),
   .cpu_wr     (cpu_wr),
   .cpu_rdata  (cpu_rdata),
   .ee_sel     (ee_sel),
   .ee_clk     (ee_clk),
   .ee_dat     (ee_dat),
   .prg_ofs    (prg_ofs),
   .misc_q     (misc_q),
   .misc_locked(misc_locked),
   .inner_clr  (inner_clr)
);

// File: tb/mcart_sup_regs_tb.sv
module mcart_sup_regs_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = 16'h0000;
   logic [7:0]  wdata = 8'h00;
   logic        wr = 1'b0;
   logic        ee_do = 1'b0;

   logic [7:0]  rd   [2];
   logic        esel [2];
   logic        eclk [2];
   logic        edat [2];
   logic [7:0]  msel [2];
   logic [3:0]  mflg [2];
   logic [15:0] pofs [2];
   logic [7:0]  mq   [2];
   logic [7:0]  m2q  [2];
   logic        lck  [2];
   logic        clr  [2];

   // expected model
   logic [7:0]  x_sel  [2];
   logic [3:0]  x_flg  [2];
   logic [15:0] x_ofs  [2];
   logic [7:0]  x_misc [2];
   logic [7:0]  x_m2   [2];
   logic [2:0]  x_pins [2];

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mcart_sup_regs #(.VARIANT(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_addr(addr), .cpu_wdata(wdata), .cpu_wr(wr),
      .cpu_rdata(rd[0]), .ee_do(ee_do), .ee_sel(esel[0]), .ee_clk(eclk[0]),
      .ee_dat(edat[0]), .map_sel(msel[0]), .map_flags(mflg[0]), .prg_ofs(pofs[0]),
      .misc_q(mq[0]), .misc2_q(m2q[0]), .misc_locked(lck[0]), .inner_clr(clr[0]));

   mcart_sup_regs #(.VARIANT(1)) dut_v1_i (
      .clk(clk), .rst_n(rst_n), .cpu_addr(addr), .cpu_wdata(wdata), .cpu_wr(wr),
      .cpu_rdata(rd[1]), .ee_do(ee_do), .ee_sel(esel[1]), .ee_clk(eclk[1]),
      .ee_dat(edat[1]), .map_sel(msel[1]), .map_flags(mflg[1]), .prg_ofs(pofs[1]),
      .misc_q(mq[1]), .misc2_q(m2q[1]), .misc_locked(lck[1]), .inner_clr(clr[1]));

   task automatic chk(input string req, input string what, input int v,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s v%0d %s actual=%h expected=%h", req, v, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int v = 0; v < 2; v++) begin
         x_sel[v]  = 8'(v << 4);
         x_flg[v]  = 4'hF;
         x_ofs[v]  = 16'h7FF0;
         x_misc[v] = 8'h00;
         x_m2[v]   = 8'h00;
         x_pins[v] = 3'b110;
      end
   endtask

   task automatic model_write(input logic [15:0] a, input logic [7:0] d);
      for (int v = 0; v < 2; v++) begin
         case (a)
            16'h5700: begin
               x_sel[v]    = 8'((v << 4) + (d >> 4));
               x_flg[v]    = d[3:0];
               x_ofs[v][4] = d[0];
            end
            16'h5701: x_ofs[v][12:5] = d;
            16'h5601: begin
               if (!x_misc[v][7]) begin
                  x_misc[v] = d;
                  if (v != 1) x_ofs[v][13] = d[4];
               end
               if (v == 1) x_pins[v] = {d[4], d[1], d[0]};
            end
            16'h5301: if (v == 0) x_pins[v] = d[2:0];
            16'h5702: if (v == 1) x_m2[v] = d;
            default: ;
         endcase
      end
   endtask

   task automatic check_state(input string req);
      for (int v = 0; v < 2; v++) begin
         chk(req, "map_sel", v, 32'(msel[v]), 32'(x_sel[v]));
         chk(req, "map_flags", v, 32'(mflg[v]), 32'(x_flg[v]));
         chk(req, "prg_ofs", v, 32'(pofs[v]), 32'(x_ofs[v]));
         chk(req, "misc_q", v, 32'(mq[v]), 32'(x_misc[v]));
         chk(req, "misc2_q", v, 32'(m2q[v]), 32'(x_m2[v]));
         chk(req, "misc_locked", v, 32'(lck[v]), 32'(x_misc[v][7]));
         chk(req, "pins", v, 32'({esel[v], eclk[v], edat[v]}), 32'(x_pins[v]));
      end
   endtask

   // One write strobe; outputs sampled at the following falling edge.
   task automatic do_write(input string req, input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0; addr = 16'h0000;
      model_write(a, d);
      check_state(req);
      for (int v = 0; v < 2; v++)
         chk("R2", "inner_clr pulse", v, 32'(clr[v]), 32'(a == 16'h5700));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      @(negedge clk);
      check_state("R1");
      for (int v = 0; v < 2; v++) chk("R1", "inner_clr", v, 32'(clr[v]), 32'd0);
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1");
      for (int v = 0; v < 2; v++) chk("R1", "inner_clr", v, 32'(clr[v]), 32'd0);

      // R10: nothing visible during the strobe cycle itself
      @(negedge clk);
      addr = 16'h5701; wdata = 8'h5A; wr = 1'b1;
      #1;
      for (int v = 0; v < 2; v++)
         chk("R10", "prg_ofs before edge", v, 32'(pofs[v]), 32'(x_ofs[v]));
      @(negedge clk);
      wr = 1'b0; addr = 16'h0000;
      model_write(16'h5701, 8'h5A);
      check_state("R10");

      // R2: sweep select/flags register, clear pulse lasts one cycle
      for (int d = 0; d < 256; d++) begin
         do_write("R2", 16'h5700, 8'(d));
         @(negedge clk);
         for (int v = 0; v < 2; v++)
            chk("R2", "inner_clr fall", v, 32'(clr[v]), 32'd0);
      end

      // R3 and R9: sweep middle offset field
      for (int d = 0; d < 256; d++) begin
         do_write("R3", 16'h5701, 8'(d ^ 8'hA5));
         for (int v = 0; v < 2; v++)
            chk("R9", "fixed ofs bits", v, 32'({pofs[v][15:14], pofs[v][3:0]}), 32'h10);
      end

      // R6: variant-0 pin address sweep (variant 1 ignores it)
      for (int d = 0; d < 16; d++) do_write("R6", 16'h5301, 8'(d * 8'h13));

      // R4, R5, R7: lock sequence
      do_write("R5", 16'h5601, 8'h13);
      do_write("R5", 16'h5601, 8'h0C);
      do_write("R7", 16'h5601, 8'h12);
      do_write("R4", 16'h5601, 8'h80);
      do_write("R4", 16'h5601, 8'h17);
      do_write("R7", 16'h5601, 8'h00);
      do_write("R4", 16'h5601, 8'h7F);
      for (int v = 0; v < 2; v++) chk("R4", "locked", v, 32'(lck[v]), 32'd1);

      // R7: second misc register
      do_write("R7", 16'h5702, 8'hA5);
      do_write("R7", 16'h5702, 8'h3C);

      // R9: undecoded addresses change nothing
      do_write("R9", 16'h4700, 8'hFF);
      do_write("R9", 16'h6701, 8'h00);
      do_write("R9", 16'h5703, 8'h55);
      do_write("R9", 16'h1601, 8'h00);
      do_write("R9", 16'h5300, 8'h07);

      // R8: read sweep over the whole window and a few outside
      for (int e = 0; e < 2; e++) begin
         ee_do = e[0];
         for (int a = 16'h4FF0; a < 16'h6010; a++) begin
            addr = 16'(a);
            #1;
            for (int v = 0; v < 2; v++)
               chk("R8", "cpu_rdata", v, 32'(rd[v]),
                   (a == 16'h5301 || a == 16'h5601) ? 32'(e << 7) : 32'hFF);
         end
      end
      ee_do = 1'b0;
      addr = 16'h0000;

      // R1 / R4: reset releases the lock
      do_reset();
      do_write("R4", 16'h5601, 8'h21);
      do_write("R5", 16'h5601, 8'h00);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule